// File: doc/BRIEF.md
# Serial EEPROM Write Collection Buffer

This block sits behind the two-wire protocol engine of a 4 kbit serial EEPROM model. It gathers the byte address and the data bytes of one write transaction into a row-sized staging buffer. When the STOP condition arrives, it writes the received bytes into a 512 x 8 storage array in a single cycle. It then holds a busy flag for a programming interval whose length is a parameter, so a bench can shrink milliseconds down to a few clock cycles.

The transfer style is fixed by the mode input at the moment the transaction opens. With mode low, page style applies: the bytes stay inside one 8-byte row, and only the low three bits of the cursor advance. With mode high, multibyte style applies: up to four bytes land at consecutive addresses from any start point. If a multibyte transfer touches more than one 4-byte group, the programming interval is doubled.

A write-control input held high turns the transaction into one that is acknowledged but leaves memory untouched. A per-byte permission input from the protection checker can veto single locations. A read port exposes the array.

Top module: `eeprom_wrbuf`

## Requirements
- R1: After reset every array location reads 0xFF, and `busy_o` and `ack_o` are low.
- R2: With `mode_i` low at the start pulse, data byte k (counting from 0) targets the row of `addr_i` at column (`addr_i[2:0]` + k) mod 8. When a column is hit again, the later byte replaces the earlier one.
- R3: With `mode_i` high (and `wc_i` low) at the start pulse, data byte k (k < 4) targets address {`addr_i[8]`, (`addr_i[7:0]` + k) mod 256}. Bytes after the fourth are dropped.
- R4: A transaction carrying a single data byte writes that byte at `addr_i` whatever the level of `mode_i`.
- R5: The array is unchanged until the STOP pulse. All accepted bytes become visible on the read port in the cycle after STOP.
- R6: A committing STOP raises `busy_o` on the next cycle for PROG_CYCLES cycles. While `busy_o` is high, start pulses are ignored, so any following data strobes get no acknowledge.
- R7: A multibyte transaction whose stored addresses differ from the start address in bits 7:2 keeps `busy_o` high for 2*PROG_CYCLES cycles. Page transactions never double.
- R8: With `wc_i` high at the start pulse, the bytes are acknowledged but no location changes. The busy interval is the nominal PROG_CYCLES, even with `mode_i` high.
- R9: An abort pulse discards the open transaction and starts no busy interval. An abort in the same cycle as STOP wins.
- R10: `ack_o` is high for one cycle after each data strobe that arrives during an open transaction, including strobes past the mode's byte limit.
- R11: A byte received with `wr_allow_i` low leaves its location unchanged, while the other bytes of the same transaction are written.
- R12: A STOP after a start pulse with no data bytes writes nothing and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Opens a write transaction (one-cycle pulse) |
| addr_i | input | 9 | Start address, sampled with `wr_start_i` |
| mode_i | input | 1 | 1 = multibyte, 0 = page, sampled with `wr_start_i` |
| wc_i | input | 1 | Write control: 1 = transaction leaves memory unchanged |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| wr_allow_i | input | 1 | Permission for the current byte's location |
| stop_i | input | 1 | STOP condition pulse, triggers commit |
| abort_i | input | 1 | Repeated START before STOP, discards the transaction |
| rd_addr_i | input | 9 | Read address |
| ack_o | output | 1 | Acknowledge, one cycle after an accepted strobe |
| busy_o | output | 1 | Programming interval in progress |
| rd_data_o | output | 8 | Array content at `rd_addr_i` |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

The first pair is abort and STOP. The bench drives both pulses together on an open transaction with one buffered byte. The expected result is that `busy_o` stays low and the location keeps 0xFF.

The second pair is a start pulse and the last cycle of a programming interval. The bench counts the interval down and places the start pulse on exactly that final busy cycle. A data strobe then follows once `busy_o` has dropped. The start must have been ignored, so the strobe must produce no acknowledge. A cycle-accurate behavioural model judges both cases on every clock.

// File: rtl/eeprom_wrbuf_pkg.sv
package eeprom_wrbuf_pkg;
  typedef enum logic {
    WM_PAGE  = 1'b0,
    WM_MULTI = 1'b1
  } wmode_e;
endpackage

// File: rtl/eeprom_wrbuf_collect.sv
module eeprom_wrbuf_collect
  import eeprom_wrbuf_pkg::*;
#(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int ROW_W     = 3,
  parameter int MULTI_MAX = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                busy_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                mode_i,
  input  logic                wc_i,
  input  logic                data_vld_i,
  input  logic [DW-1:0]       data_i,
  input  logic                allow_i,
  input  logic                stop_i,
  input  logic                abort_i,
  output logic                ack_o,
  output logic                commit_o,
  output logic                long_o,
  output logic [(1<<ROW_W)-1:0] slot_we_o,
  output logic [AW-1:0]       slot_addr_o [1<<ROW_W],
  output logic [DW-1:0]       slot_data_o [1<<ROW_W]
);
  localparam int LW   = AW - 1;
  localparam int ROWN = 1 << ROW_W;
  localparam int GW   = $clog2(MULTI_MAX);
  localparam int CNTW = $clog2(MULTI_MAX + 1);

  logic            active_q, wc_q, long_q;
  wmode_e          mode_q;
  logic [AW-1:0]   base_q;
  logic [LW-1:0]   ptr_q, ptr_nxt;
  logic [CNTW-1:0] cnt_q;
  logic [ROWN-1:0] vmask_q, okmask_q;
  logic [DW-1:0]   sdata_q [ROWN];
  logic            go, take, store;
  logic [ROW_W-1:0] slot;

  assign go    = start_i & ~busy_i;
  assign take  = data_vld_i & active_q & ~stop_i & ~abort_i & ~go;
  assign store = take & ((mode_q == WM_PAGE) | (cnt_q < CNTW'(MULTI_MAX)));
  assign slot  = ptr_q[ROW_W-1:0];

  // page mode advances only the column bits
  assign ptr_nxt = (mode_q == WM_MULTI) ? ptr_q + 1'b1
                                        : {ptr_q[LW-1:ROW_W], slot + 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= WM_PAGE;
      wc_q     <= 1'b0;
      long_q   <= 1'b0;
      base_q   <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      vmask_q  <= '0;
      okmask_q <= '0;
      ack_o    <= 1'b0;
      for (int i = 0; i < ROWN; i++) sdata_q[i] <= '0;
    end else begin
      ack_o <= take;
      if (go) begin
        active_q <= 1'b1;
        mode_q   <= (mode_i & ~wc_i) ? WM_MULTI : WM_PAGE;
        wc_q     <= wc_i;
        base_q   <= addr_i;
        ptr_q    <= addr_i[LW-1:0];
        cnt_q    <= '0;
        long_q   <= 1'b0;
        vmask_q  <= '0;
      end else if (active_q && (abort_i || stop_i)) begin
        active_q <= 1'b0;
        vmask_q  <= '0;
      end else if (store) begin
        sdata_q[slot]  <= data_i;
        vmask_q[slot]  <= 1'b1;
        okmask_q[slot] <= allow_i;
        ptr_q          <= ptr_nxt;
        if (mode_q == WM_MULTI) begin
          cnt_q <= cnt_q + 1'b1;
          if (ptr_q[LW-1:GW] != base_q[LW-1:GW]) long_q <= 1'b1;
        end
      end
    end
  end

  assign commit_o = active_q & stop_i & ~abort_i & ~go & (|vmask_q);
  assign long_o   = long_q;

  for (genvar g = 0; g < ROWN; g++) begin : g_slot
    logic [ROW_W-1:0] off;
    assign off = ROW_W'(g) - base_q[ROW_W-1:0];
    assign slot_addr_o[g] = (mode_q == WM_MULTI)
      ? {base_q[AW-1], base_q[LW-1:0] + {{(LW-ROW_W){1'b0}}, off}}
      : {base_q[AW-1:ROW_W], ROW_W'(g)};
    assign slot_data_o[g] = sdata_q[g];
    assign slot_we_o[g]   = commit_o & vmask_q[g] & okmask_q[g] & ~wc_q;
  end
endmodule

// File: rtl/eeprom_wrbuf_timer.sv
module eeprom_wrbuf_timer #(
  parameter int PROG_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int CW = $clog2(2 * PROG_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= long_i ? CW'(2 * PROG_CYCLES) : CW'(PROG_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_wrbuf_array.sv
module eeprom_wrbuf_array #(
  parameter int AW   = 9,
  parameter int DW   = 8,
  parameter int PORTS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PORTS-1:0] we_i,
  input  logic [AW-1:0]    waddr_i [PORTS],
  input  logic [DW-1:0]    wdata_i [PORTS],
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      for (int p = 0; p < PORTS; p++)
        if (we_i[p]) mem_q[waddr_i[p]] <= wdata_i[p];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_wrbuf.sv
module eeprom_wrbuf #(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int ROW_W       = 3,
  parameter int MULTI_MAX   = 4,
  parameter int PROG_CYCLES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mode_i,
  input  logic          wc_i,
  input  logic          data_vld_i,
  input  logic [DW-1:0] data_i,
  input  logic          wr_allow_i,
  input  logic          stop_i,
  input  logic          abort_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          ack_o,
  output logic          busy_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int ROWN = 1 << ROW_W;

  logic            commit, long_span;
  logic [ROWN-1:0] slot_we;
  logic [AW-1:0]   slot_addr [ROWN];
  logic [DW-1:0]   slot_data [ROWN];

  eeprom_wrbuf_collect #(
    .AW(AW), .DW(DW), .ROW_W(ROW_W), .MULTI_MAX(MULTI_MAX)
  ) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (wr_start_i),
    .busy_i     (busy_o),
    .addr_i     (addr_i),
    .mode_i     (mode_i),
    .wc_i       (wc_i),
    .data_vld_i (data_vld_i),
    .data_i     (data_i),
    .allow_i    (wr_allow_i),
    .stop_i     (stop_i),
    .abort_i    (abort_i),
    .ack_o      (ack_o),
    .commit_o   (commit),
    .long_o     (long_span),
    .slot_we_o  (slot_we),
    .slot_addr_o(slot_addr),
    .slot_data_o(slot_data)
  );

  eeprom_wrbuf_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(commit),
    .long_i(long_span),
    .busy_o(busy_o)
  );

  eeprom_wrbuf_array #(.AW(AW), .DW(DW), .PORTS(ROWN)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (slot_we),
    .waddr_i(slot_addr),
    .wdata_i(slot_data),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/eeprom_wrbuf_chk.sv
module eeprom_wrbuf_chk #(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          data_vld_i,
  input logic          stop_i,
  input logic          abort_i,
  input logic [AW-1:0] rd_addr_i,
  input logic          ack_o,
  input logic          busy_o,
  input logic [DW-1:0] rd_data_o
);
  int run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R10
  ack_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(data_vld_i));

  // R6
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  // R7
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == PROG_CYCLES || run_q == 2 * PROG_CYCLES));

  // R9
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !busy_o) |=> !busy_o);

  // R5
  hold_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_addr_i) && !$past(stop_i)) |-> $stable(rd_data_o));
endmodule

bind eeprom_wrbuf eeprom_wrbuf_chk #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_vld_i(data_vld_i),
  .stop_i    (stop_i),
  .abort_i   (abort_i),
  .rd_addr_i (rd_addr_i),
  .ack_o     (ack_o),
  .busy_o    (busy_o),
  .rd_data_o (rd_data_o)
);

// File: tb/sim_eeprom_wrbuf.sv
`timescale 1ns/1ps
module sim_eeprom_wrbuf;
  localparam int N = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_start = 0, mode = 0, wc = 0, data_vld = 0, allow = 1, stop = 0, abort = 0;
  logic [8:0] addr = '0, rd_addr = '0;
  logic [7:0] data = '0;
  logic       ack_o, busy_o;
  logic [7:0] rd_data_o;

  always #5 clk = ~clk;

  eeprom_wrbuf #(.PROG_CYCLES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr_start), .addr_i(addr),
    .mode_i(mode), .wc_i(wc), .data_vld_i(data_vld), .data_i(data),
    .wr_allow_i(allow), .stop_i(stop), .abort_i(abort), .rd_addr_i(rd_addr),
    .ack_o(ack_o), .busy_o(busy_o), .rd_data_o(rd_data_o)
  );

  int errs = 0, checks = 0, acks = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct {int a; int d; bit ok;} ent_t;
  int   mem [512];
  ent_t q[$];
  bit   m_act, m_multi, m_wc, m_ack, go, sp;
  int   m_base, m_n, m_cnt, a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 255;
      q.delete();
      m_act = 0; m_cnt = 0; m_ack = 0; m_multi = 0; m_wc = 0; m_base = 0; m_n = 0;
    end else begin
      go    = wr_start && (m_cnt == 0);
      m_ack = data_vld && m_act && !stop && !abort && !go;
      if (m_cnt > 0) m_cnt--;
      if (go) begin
        m_act = 1; m_multi = mode && !wc; m_wc = wc; m_base = addr; m_n = 0; q.delete();
      end else if (m_act && abort) begin
        m_act = 0; q.delete();
      end else if (m_act && stop) begin
        m_act = 0;
        if (q.size() > 0) begin
          sp = 0;
          foreach (q[i]) begin
            if (q[i].ok && !m_wc) mem[q[i].a] = q[i].d;
            if (m_multi && (((q[i].a >> 2) & 63) != ((m_base >> 2) & 63))) sp = 1;
          end
          m_cnt = sp ? 2 * N : N;
        end
        q.delete();
      end else if (m_act && data_vld) begin
        if (!m_multi) a = (m_base & ~7) | ((m_base + m_n) & 7);
        else          a = (m_base & 256) | ((m_base + m_n) & 255);
        if (!m_multi || m_n < 4) q.push_back('{a, int'(data), allow});
        m_n++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 busy per cycle", busy_o, int'(m_cnt != 0));
      check("R10 ack per cycle", ack_o, int'(m_ack));
      check("R5 rd_data per cycle", rd_data_o, mem[rd_addr]);
      if (ack_o) acks++;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    wr_start = 0; data_vld = 0; stop = 0; abort = 0;
  endtask
  task automatic t_start(int ad, bit m, bit w);
    tick(); wr_start = 1; addr = 9'(ad); mode = m; wc = w;
  endtask
  task automatic t_byte(int d, bit al);
    tick(); data_vld = 1; data = 8'(d); allow = al;
  endtask
  task automatic t_stop();
    tick(); stop = 1;
  endtask
  task automatic wait_busy(output int len);
    tick(); len = 0;
    while (busy_o) begin len++; tick(); end
  endtask
  task automatic rd(int ad, int exp, string tag);
    tick(); rd_addr = 9'(ad); #1;
    check(tag, rd_data_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(9'h000, 8'hFF, "R1 reset mem[000]");
    rd(9'h1FF, 8'hFF, "R1 reset mem[1FF]");
    check("R1 reset busy", busy_o, 0);
    check("R1 reset ack", ack_o, 0);

    // R2 page wrap, R5 not before stop, R10 ack past limit
    acks = 0;
    t_start(9'h01D, 0, 0);
    for (int k = 0; k < 10; k++) t_byte(8'hA0 + k, 1);
    tick();
    check("R10 acks page 10 bytes", acks, 10);
    rd(9'h01D, 8'hFF, "R5 mem before stop");
    t_stop(); wait_busy(len);
    check("R6 busy length page", len, N);
    rd(9'h01D, 8'hA8, "R2 overwrite 01D");
    rd(9'h01E, 8'hA9, "R2 overwrite 01E");
    rd(9'h01F, 8'hA2, "R2 column 7");
    rd(9'h018, 8'hA3, "R2 wrap to column 0");
    rd(9'h020, 8'hFF, "R2 next row untouched");

    // R3 multibyte across block edge, R7 doubled
    acks = 0;
    t_start(9'h0FE, 1, 0);
    for (int k = 0; k < 6; k++) t_byte(8'hB0 + k, 1);
    t_stop(); wait_busy(len);
    check("R7 doubled busy", len, 2 * N);
    check("R10 acks multi 6 bytes", acks, 6);
    rd(9'h0FF, 8'hB1, "R3 byte 1");
    rd(9'h000, 8'hB2, "R3 wrap in block");
    rd(9'h001, 8'hB3, "R3 byte 3");
    rd(9'h002, 8'hFF, "R3 fifth byte dropped");
    rd(9'h100, 8'hFF, "R3 other block untouched");

    // R7 multibyte within one group
    t_start(9'h104, 1, 0);
    for (int k = 0; k < 3; k++) t_byte(8'hD0 + k, 1);
    t_stop(); wait_busy(len);
    check("R7 nominal busy", len, N);
    rd(9'h106, 8'hD2, "R3 byte 2 at 106");

    // R4 single byte either mode
    t_start(9'h150, 1, 0); t_byte(8'h5A, 1); t_stop(); wait_busy(len);
    t_start(9'h153, 0, 0); t_byte(8'h6B, 1); t_stop(); wait_busy(len);
    rd(9'h150, 8'h5A, "R4 single multi mode");
    rd(9'h153, 8'h6B, "R4 single page mode");

    // R8 write control
    acks = 0;
    t_start(9'h1FE, 1, 1);
    for (int k = 0; k < 4; k++) t_byte(8'hE0 + k, 1);
    t_stop(); wait_busy(len);
    check("R8 acks under wc", acks, 4);
    check("R8 nominal busy under wc", len, N);
    rd(9'h1FE, 8'hFF, "R8 1FE unchanged");
    rd(9'h1FF, 8'hFF, "R8 1FF unchanged");

    // R11 per-byte permission
    t_start(9'h060, 0, 0);
    t_byte(8'hC0, 1); t_byte(8'hC1, 0); t_byte(8'hC2, 1);
    t_stop(); wait_busy(len);
    rd(9'h060, 8'hC0, "R11 allowed 060");
    rd(9'h061, 8'hFF, "R11 vetoed 061");
    rd(9'h062, 8'hC2, "R11 allowed 062");

    // R9 abort, then abort together with stop
    t_start(9'h070, 0, 0); t_byte(8'h11, 1); t_byte(8'h12, 1);
    tick(); abort = 1; tick(); tick();
    check("R9 no busy after abort", busy_o, 0);
    rd(9'h070, 8'hFF, "R9 aborted data");
    t_start(9'h071, 0, 0); t_byte(8'h13, 1);
    tick(); abort = 1; stop = 1; tick(); tick();
    check("R9 abort wins over stop", busy_o, 0);
    rd(9'h071, 8'hFF, "R9 abort+stop data");

    // R12 address only
    t_start(9'h080, 0, 0); t_stop(); tick();
    check("R12 no busy on empty write", busy_o, 0);

    // R6 start during busy, including its last cycle
    t_start(9'h090, 0, 0); t_byte(8'h77, 1); t_stop();
    t_start(9'h091, 0, 0);
    acks = 0;
    t_byte(8'h21, 1); t_stop();
    repeat (N - 4) tick();
    t_start(9'h092, 0, 0);
    wait_busy(len);
    t_byte(8'h22, 1); t_stop(); tick(); tick();
    check("R6 no ack after ignored starts", acks, 0);
    check("R6 no busy from ignored start", busy_o, 0);
    rd(9'h090, 8'h77, "R6 committed byte");
    rd(9'h091, 8'hFF, "R6 ignored during busy");
    rd(9'h092, 8'hFF, "R6 ignored on last busy cycle");

    repeat (3) tick();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule